// File: doc/BRIEF.md
# Johnson-Pointer Dual-Clock Flit FIFO

This block carries 34-bit flits from one clock domain to another when the two clocks have no fixed relation. An example is the point where a core with its own clock joins an on-chip network. The producer writes on its own clock and sees a full flag. The consumer reads on a separate clock and sees an empty flag. Each flit is a 32-bit payload with a begin-of-packet bit and an end-of-packet bit.

Each side keeps its position as a twisted-ring (Johnson) code. Each advance flips exactly one bit, so a two-flop synchronizer can carry a pointer into the other domain safely. With a ring of DEPTH bits there are 2·DEPTH states. That extra bit of history separates full from empty. The flags are computed from the local pointer and the synchronized copy of the remote one. This makes them late by a few cycles, but never early.

Top module: `jfifo_dc`

## Requirements
- R1: While wr_rst is held high at a wr_clk edge, wr_full is low after that edge. While rd_rst is held high at a rd_clk edge, rd_empty is high after that edge.
- R2: Flits are delivered in the order they were written. While rd_empty is low, rd_data shows the oldest unread flit, and all 34 bits are carried unchanged.
- R3: With no reads, wr_full is high right after the fourth accepted write, counted from empty, with the default DEPTH of 4.
- R4: A write attempted while wr_full is high stores nothing and does not advance the write side. After the four stored flits are read, the FIFO is empty.
- R5: A read attempted while rd_empty is high does not advance the read side. The next flit written is the next one read.
- R6: rd_empty goes high in the same read cycle that the last stored flit is read. After a write into an empty FIFO, rd_empty falls within four rd_clk cycles.
- R7: After a read from a full FIFO, wr_full falls within four wr_clk cycles.
- R8: Each pointer changes at most one bit per clock edge. Data stays correct as the pointers wrap around the ring many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | 34 | Flit to write: [33] begin-of-packet, [32] end-of-packet, [31:0] payload |
| wr_full | output | 1 | No room for another flit |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_en | input | 1 | Read request; pops the flit shown on rd_data |
| rd_data | output | 34 | Oldest unread flit, valid while rd_empty is low |
| rd_empty | output | 1 | No flit available |

## Verification
The hardest state to reach from the ports is the full-to-not-full crossing. Writes are attempted against a full FIFO, and a read then releases one slot in the other clock domain. The bench fills the FIFO with reads idle and tries an extra write. It then pops a single flit and counts write-clock cycles until wr_full falls. The two clocks run at unrelated periods, so the synchronizer phase drifts. Repeated fill-and-drain bursts walk both rings around several full wraps.

// File: rtl/jfifo_pkg.sv
package jfifo_pkg;

    localparam int PAYLOAD_W = 32;

    typedef struct packed {
        logic                 bop;
        logic                 eop;
        logic [PAYLOAD_W-1:0] payload;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);

endpackage

// File: rtl/jfifo_sync.sv
module jfifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/jfifo_jptr.sv
module jfifo_jptr #(
    parameter int W  = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1,
    localparam int CW = $clog2(2 * W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [W-1:0]  ring,
    output logic [IW-1:0] idx
);
    logic [CW-1:0] ones;
    logic [CW-1:0] cnt;

    // twisted ring: shift left, feed back the inverted top bit
    always_ff @(posedge clk) begin
        if (rst)      ring <= '0;
        else if (adv) ring <= {ring[W-2:0], ~ring[W-1]};
    end

    // ring state -> linear count -> slot index
    always_comb begin
        ones = CW'($countones(ring));
        cnt  = ring[W-1] ? (CW'(2 * W) - ones) : ones;
        idx  = IW'(cnt % CW'(W));
    end
endmodule

// File: rtl/jfifo_mem.sv
module jfifo_mem
    import jfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  flit_t         wdata,
    input  logic [IW-1:0] raddr,
    output flit_t         rdata
);
    flit_t slots [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/jfifo_dc.sv
module jfifo_dc
    import jfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [FLIT_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [FLIT_W-1:0] rd_data,
    output logic              rd_empty
);
    logic [DEPTH-1:0] w_ring, r_ring;
    logic [DEPTH-1:0] r_ring_wsync, w_ring_rsync;
    logic [IW-1:0]    w_idx, r_idx;
    logic             w_push, r_pop;
    flit_t            w_flit, r_flit;

    assign w_push = wr_en & ~wr_full;
    assign r_pop  = rd_en & ~rd_empty;

    // DEPTH steps ahead on a DEPTH-bit twisted ring is the bitwise complement
    assign wr_full  = (w_ring == ~r_ring_wsync);
    assign rd_empty = (r_ring == w_ring_rsync);

    assign w_flit  = flit_t'(wr_data);
    assign rd_data = r_flit;

    jfifo_jptr #(.W(DEPTH)) u_wptr (
        .clk(wr_clk), .rst(wr_rst), .adv(w_push), .ring(w_ring), .idx(w_idx)
    );

    jfifo_jptr #(.W(DEPTH)) u_rptr (
        .clk(rd_clk), .rst(rd_rst), .adv(r_pop), .ring(r_ring), .idx(r_idx)
    );

    jfifo_sync #(.W(DEPTH)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(r_ring), .q(r_ring_wsync)
    );

    jfifo_sync #(.W(DEPTH)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(w_ring), .q(w_ring_rsync)
    );

    jfifo_mem #(.DEPTH(DEPTH)) u_mem (
        .wclk(wr_clk), .we(w_push), .waddr(w_idx), .wdata(w_flit),
        .raddr(r_idx), .rdata(r_flit)
    );
endmodule

// File: rtl/jfifo_dc_chk.sv
module jfifo_dc_chk #(
    parameter int PW = 4
) (
    input logic          wclk,
    input logic          rclk,
    input logic          wrst,
    input logic          rrst,
    input logic          wen,
    input logic          ren,
    input logic          full,
    input logic          empty,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr
);
    AST_RESET_NOT_FULL:  assert property (@(posedge wclk) wrst |=> !full);   // R1
    AST_RESET_EMPTY:     assert property (@(posedge rclk) rrst |=> empty);   // R1
    AST_NO_OVERFLOW:     assert property (@(posedge wclk) disable iff (wrst)
                             (wen && full) |=> $stable(wptr));               // R4
    AST_NO_UNDERFLOW:    assert property (@(posedge rclk) disable iff (rrst)
                             (ren && empty) |=> $stable(rptr));              // R5
    AST_WPTR_SINGLE_BIT: assert property (@(posedge wclk) disable iff (wrst)
                             $countones(wptr ^ $past(wptr)) <= 1);           // R8
    AST_RPTR_SINGLE_BIT: assert property (@(posedge rclk) disable iff (rrst)
                             $countones(rptr ^ $past(rptr)) <= 1);           // R8
endmodule

bind jfifo_dc jfifo_dc_chk #(.PW(DEPTH)) u_chk (
    .wclk(wr_clk), .rclk(rd_clk), .wrst(wr_rst), .rrst(rd_rst),
    .wen(wr_en), .ren(rd_en), .full(wr_full), .empty(rd_empty),
    .wptr(w_ring), .rptr(r_ring)
);

// File: tb/sim_jfifo_dc.sv
module sim_jfifo_dc;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst = 1'b1, rd_rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [33:0] wr_data = '0;
    logic [33:0] rd_data;
    logic        wr_full, rd_empty;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #4   wr_clk = ~wr_clk;   // 125 MHz
    always #5.5 rd_clk = ~rd_clk;   // unrelated read clock

    jfifo_dc u0 (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic chk(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [33:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pop(input logic [33:0] exp, input string req);
        @(negedge rd_clk);
        chk(!rd_empty, {req, " not empty"}, {33'd0, rd_empty}, 34'd0);
        chk(rd_data === exp, {req, " data"}, rd_data, exp);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge rd_clk);
        wr_rst = 1'b0; rd_rst = 1'b0;
        @(negedge wr_clk);
        chk(!wr_full, "R1 full after reset", {33'd0, wr_full}, 34'd0);
        @(negedge rd_clk);
        chk(rd_empty, "R1 empty after reset", {33'd0, rd_empty}, 34'd1);
    endtask

    task automatic t_single();
        logic [33:0] v = {2'b11, 32'hA5C3_0F01};
        push(v);
        rd_wait(4);
        chk(!rd_empty, "R6 empty falls after write", {33'd0, rd_empty}, 34'd0);
        pop(v, "R2 single flit");
        chk(rd_empty, "R6 empty on last read", {33'd0, rd_empty}, 34'd1);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 4; i++) push({i[1:0], 32'h1000_0000 + 32'(i)});
        chk(wr_full, "R3 full after four writes", {33'd0, wr_full}, 34'd1);
        push({2'b01, 32'hDEAD_BEEF});   // ignored
        chk(wr_full, "R4 still full", {33'd0, wr_full}, 34'd1);
        rd_wait(5);
        pop({2'd0, 32'h1000_0000}, "R4 first kept flit");
        repeat (4) @(negedge wr_clk);
        chk(!wr_full, "R7 full falls after read", {33'd0, wr_full}, 34'd0);
        for (int i = 1; i < 4; i++) pop({i[1:0], 32'h1000_0000 + 32'(i)}, "R2 order");
        chk(rd_empty, "R4 empty after four reads", {33'd0, rd_empty}, 34'd1);
        rd_wait(6);
        chk(rd_empty, "R4 extra write not stored", {33'd0, rd_empty}, 34'd1);
    endtask

    task automatic t_read_empty();
        logic [33:0] v = {2'b10, 32'h0BAD_F00D};
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        chk(rd_empty, "R5 still empty", {33'd0, rd_empty}, 34'd1);
        push(v);
        rd_wait(5);
        pop(v, "R5 next flit after empty read");
        chk(rd_empty, "R5 empty again", {33'd0, rd_empty}, 34'd1);
    endtask

    task automatic t_wrap();
        for (int r = 0; r < 12; r++) begin
            for (int k = 0; k < 3; k++) push({r[0], k[0], 32'(r * 16 + k)});
            rd_wait(5);
            for (int k = 0; k < 3; k++) pop({r[0], k[0], 32'(r * 16 + k)}, "R8 wrap");
        end
        chk(rd_empty, "R8 empty after wraps", {33'd0, rd_empty}, 34'd1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_fill();
        t_read_empty();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge wr_clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule